// File: doc/BRIEF.md
# Protection Fault Sequencer

This block supervises a primary-side LED driver controller. It does not measure anything itself. Comparator flags arrive already digitised: supply level bands, line brown-out, the temperature and over-voltage sense pin, the die thermal monitor, the current-sense short, supply over-voltage, the output diode short and the zero-cross level. The block decides when the gate driver may switch and sequences every stop, restart and lock-out.

Every duration is counted from a single prescaled `tick` input. The limits are parameters, so the same logic can be run with short windows. A variant input picks one of two behaviours for the most serious faults. In one they are held until the supply collapses to the logic-reset level. In the other the block recovers by itself after a long wait and a fresh supply start-up.

The block has two fault classes:
- **Timer faults** stop switching, wait out the recovery window, then require the supply to fall and climb again.
- **Immediate faults** send the machine directly to reset or to supply discharge.

Top module: `protSequencer`

## Requirements
- R1: After `rstN` the state code is 0. The codes are reset=0, stop=1, run=2, discharge=3, recover=4 and latch=5. In reset, `gateEn` is 0 and `startupMode` is 1.
- R2: From reset, `vccAboveStart` with no brown-out and no `vccBelowReset` moves the machine to stop. It enters run after SETTLE_TICKS ticks. `gateEn` is 1 only in run.
- R3: In run or stop, `vccBelowStop` moves the machine to discharge. Discharge moves to reset once `vccBelowStop` is seen.
- R4: In stop or run, any of the following moves the machine to recover: supply over-voltage, a confirmed pin over-voltage, a current-sense short, and (in the auto variant) a diode short, an auxiliary short or a confirmed over-temperature. After RECOVER_TICKS ticks the machine goes to discharge, so a restart needs a fresh supply climb.
- R5: In stop or run, brown-out moves the machine to reset. It stays in reset while brown-out is held. When brown-out clears with `vccAboveStart` high, the machine goes straight to stop.
- R6: In stop or run, die thermal shutdown moves the machine to discharge.
- R7: With `latchedVariant`=1, a diode short, an auxiliary short or a confirmed over-temperature moves the machine to latch. Latch is left only through `vccBelowReset`. In latch, `startupMode` follows the supply hiccup: it goes to 1 on `vccBelowStop` and to 0 on `vccAboveStart`.
- R8: An over-temperature recovery in the auto variant leaves recover only when the timer has expired and `senseRelease` is 1.
- R9: An auxiliary short is flagged only after `zcdLow` has stayed high for AUX_TICKS consecutive ticks. A shorter run has no effect.
- R10: `senseLow` and `senseHigh` are confirmed only after CONFIRM_TICKS consecutive ticks. A shorter pulse has no effect.
- R11: No timer or filter advances on a cycle without `tick`.
- R12: `vccBelowReset` sends the machine to reset from every state, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| tick | input | 1 | prescaled time-base strobe |
| latchedVariant | input | 1 | 1 selects the latching behaviour |
| vccAboveStart | input | 1 | supply above start level |
| vccBelowStop | input | 1 | supply below stop level |
| vccBelowReset | input | 1 | supply below logic-reset level |
| brownOut | input | 1 | line voltage too low |
| senseLow | input | 1 | sense pin below over-temperature level |
| senseRelease | input | 1 | sense pin above over-temperature release level |
| senseHigh | input | 1 | sense pin above over-voltage level |
| dieHot | input | 1 | die thermal shutdown |
| csShort | input | 1 | current-sense pin short |
| vccOver | input | 1 | supply over-voltage |
| diodeShort | input | 1 | winding or output diode short |
| zcdLow | input | 1 | zero-cross input below short threshold |
| gateEn | output | 1 | gate drive enable |
| startupMode | output | 1 | startup current source active |
| stateCode | output | 3 | current state code |

## Verification
The hardest situations to reach from the ports are the two multi-condition exits. The first is leaving recover after an over-temperature, which needs both the expired timer and the release flag. The second is leaving latch, which needs the supply to drop below reset rather than below stop.

Directed sequences build each of these up in order: timer expiry with release held low, then release raised, and latch followed by a full stop/start hiccup before the reset drop. Random fault choices under both variants then check where the machine lands from run. Sub-threshold pulses on the filtered inputs confirm that short glitches change nothing.

// File: rtl/protPkg.sv
package protPkg;
  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_STOP    = 3'd1,
    ST_RUN     = 3'd2,
    ST_DISCH   = 3'd3,
    ST_RECOVER = 3'd4,
    ST_LATCH   = 3'd5
  } seqState_t;

  typedef struct packed {
    logic clrTimer;
    logic runTimer;
  } ctlStrobe_t;

  typedef struct packed {
    logic settleDone;
    logic recoverDone;
    logic auxShort;
    logic otpConf;
    logic ovpConf;
  } dpStatus_t;
endpackage

// File: rtl/persistFilter.sv
module persistFilter #(
  parameter int LIMIT = 30
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic level,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  // Count consecutive ticks with the level high; any low cycle restarts the window.
  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (!level) cnt <= '0;
    else if (tick && cnt != W'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == W'(LIMIT));
endmodule

// File: rtl/protTimers.sv
module protTimers
  import protPkg::*;
#(
  parameter int SETTLE_TICKS  = 200,
  parameter int RECOVER_TICKS = 4000000,
  parameter int AUX_TICKS     = 90000,
  parameter int CONFIRM_TICKS = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       zcdLow,
  input  logic       senseLow,
  input  logic       senseHigh,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status
);
  localparam int TMAX = (SETTLE_TICKS > RECOVER_TICKS) ? SETTLE_TICKS : RECOVER_TICKS;
  localparam int TW   = $clog2(TMAX + 1);

  logic [TW-1:0] tCnt;

  // One shared state timer: it serves the settle window in stop and the recovery window.
  always_ff @(posedge clk) begin
    if (!rstN) tCnt <= '0;
    else if (strobe.clrTimer) tCnt <= '0;
    else if (strobe.runTimer && tick && tCnt != TW'(TMAX)) tCnt <= tCnt + 1'b1;
  end

  assign status.settleDone  = (tCnt >= TW'(SETTLE_TICKS));
  assign status.recoverDone = (tCnt >= TW'(RECOVER_TICKS));

  persistFilter #(.LIMIT(AUX_TICKS)) i_auxFilt (
    .clk(clk), .rstN(rstN), .tick(tick), .level(zcdLow), .hit(status.auxShort));
  persistFilter #(.LIMIT(CONFIRM_TICKS)) i_otpFilt (
    .clk(clk), .rstN(rstN), .tick(tick), .level(senseLow), .hit(status.otpConf));
  persistFilter #(.LIMIT(CONFIRM_TICKS)) i_ovpFilt (
    .clk(clk), .rstN(rstN), .tick(tick), .level(senseHigh), .hit(status.ovpConf));
endmodule

// File: rtl/protFsm.sv
module protFsm
  import protPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       latchedVariant,
  input  logic       vccAboveStart,
  input  logic       vccBelowStop,
  input  logic       vccBelowReset,
  input  logic       brownOut,
  input  logic       senseRelease,
  input  logic       dieHot,
  input  logic       csShort,
  input  logic       vccOver,
  input  logic       diodeShort,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output seqState_t  state,
  output logic       gateEn,
  output logic       startupMode
);
  seqState_t nextState;
  logic otpCause;
  logic charging;
  logic latchFault;
  logic timerFault;

  assign latchFault = latchedVariant && (diodeShort || status.auxShort || status.otpConf);
  assign timerFault = vccOver || status.ovpConf || csShort || diodeShort
                    || status.auxShort || status.otpConf;

  always_comb begin
    nextState = state;
    if (vccBelowReset) nextState = ST_RESET;
    else begin
      unique case (state)
        ST_RESET:
          if (!brownOut && vccAboveStart) nextState = ST_STOP;
        ST_STOP, ST_RUN: begin
          // Fault priority: lock-out first, then immediate stops, then timed recovery.
          if (latchFault) nextState = ST_LATCH;
          else if (brownOut) nextState = ST_RESET;
          else if (dieHot) nextState = ST_DISCH;
          else if (timerFault) nextState = ST_RECOVER;
          else if (vccBelowStop) nextState = ST_DISCH;
          else if (state == ST_STOP && status.settleDone) nextState = ST_RUN;
        end
        ST_DISCH:
          if (vccBelowStop) nextState = ST_RESET;
        ST_RECOVER:
          if (status.recoverDone && (!otpCause || senseRelease)) nextState = ST_DISCH;
        ST_LATCH: nextState = ST_LATCH;
        default: nextState = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_RESET;
      otpCause <= 1'b0;
      charging <= 1'b1;
    end else begin
      state <= nextState;
      if (state != ST_RECOVER && nextState == ST_RECOVER) otpCause <= status.otpConf;
      if (vccBelowStop) charging <= 1'b1;
      else if (vccAboveStart) charging <= 1'b0;
    end
  end

  assign strobe.clrTimer = (nextState != state);
  assign strobe.runTimer = (state == ST_STOP) || (state == ST_RECOVER);
  assign gateEn          = (state == ST_RUN);
  assign startupMode     = (state == ST_RESET) || (state == ST_LATCH && charging);
endmodule

// File: rtl/protSequencer.sv
module protSequencer
  import protPkg::*;
#(
  parameter int SETTLE_TICKS  = 200,
  parameter int RECOVER_TICKS = 4000000,
  parameter int AUX_TICKS     = 90000,
  parameter int CONFIRM_TICKS = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       latchedVariant,
  input  logic       vccAboveStart,
  input  logic       vccBelowStop,
  input  logic       vccBelowReset,
  input  logic       brownOut,
  input  logic       senseLow,
  input  logic       senseRelease,
  input  logic       senseHigh,
  input  logic       dieHot,
  input  logic       csShort,
  input  logic       vccOver,
  input  logic       diodeShort,
  input  logic       zcdLow,
  output logic       gateEn,
  output logic       startupMode,
  output logic [2:0] stateCode
);
  ctlStrobe_t strobe;
  dpStatus_t  status;
  seqState_t  state;

  protTimers #(
    .SETTLE_TICKS(SETTLE_TICKS), .RECOVER_TICKS(RECOVER_TICKS),
    .AUX_TICKS(AUX_TICKS), .CONFIRM_TICKS(CONFIRM_TICKS)
  ) i_timers (
    .clk(clk), .rstN(rstN), .tick(tick), .zcdLow(zcdLow),
    .senseLow(senseLow), .senseHigh(senseHigh), .strobe(strobe), .status(status));

  protFsm i_fsm (
    .clk(clk), .rstN(rstN), .latchedVariant(latchedVariant),
    .vccAboveStart(vccAboveStart), .vccBelowStop(vccBelowStop),
    .vccBelowReset(vccBelowReset), .brownOut(brownOut), .senseRelease(senseRelease),
    .dieHot(dieHot), .csShort(csShort), .vccOver(vccOver), .diodeShort(diodeShort),
    .status(status), .strobe(strobe), .state(state), .gateEn(gateEn),
    .startupMode(startupMode));

  assign stateCode = state;
endmodule

// File: rtl/protSequencerChk.sv
module protSequencerChk (
  input logic       clk,
  input logic       rstN,
  input logic       latchedVariant,
  input logic       vccBelowStop,
  input logic       vccBelowReset,
  input logic       gateEn,
  input logic [2:0] stateCode
);
  AST_GATE_FROM_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateEn) |-> $past(stateCode) == 3'd1);                               // R2

  AST_RUN_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    gateEn && vccBelowStop |=> !gateEn);                                       // R3

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stateCode == 3'd5 && !vccBelowReset |=> stateCode == 3'd5);                // R7

  AST_NO_LATCH_AUTO: assert property (@(posedge clk) disable iff (!rstN)
    stateCode != 3'd5 && !latchedVariant |=> stateCode != 3'd5);               // R4

  AST_RESET_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    vccBelowReset |=> stateCode == 3'd0);                                      // R12

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    stateCode <= 3'd5);                                                        // R1
endmodule

bind protSequencer protSequencerChk i_chk (
  .clk(clk), .rstN(rstN), .latchedVariant(latchedVariant),
  .vccBelowStop(vccBelowStop), .vccBelowReset(vccBelowReset),
  .gateEn(gateEn), .stateCode(stateCode));

// File: tb/test_protSequencer.sv
`timescale 1ns/1ps
module test_protSequencer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1;
  logic latchedVariant = 1'b0;
  logic vccAboveStart = 1'b0, vccBelowStop = 1'b1, vccBelowReset = 1'b1;
  logic brownOut = 1'b0, senseLow = 1'b0, senseRelease = 1'b0, senseHigh = 1'b0;
  logic dieHot = 1'b0, csShort = 1'b0, vccOver = 1'b0, diodeShort = 1'b0, zcdLow = 1'b0;
  logic gateEn, startupMode;
  logic [2:0] stateCode;
  int nVec = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  protSequencer #(.SETTLE_TICKS(8), .RECOVER_TICKS(20), .AUX_TICKS(6), .CONFIRM_TICKS(3))
  i_protSequencer (
    .clk(clk), .rstN(rstN), .tick(tick), .latchedVariant(latchedVariant),
    .vccAboveStart(vccAboveStart), .vccBelowStop(vccBelowStop), .vccBelowReset(vccBelowReset),
    .brownOut(brownOut), .senseLow(senseLow), .senseRelease(senseRelease),
    .senseHigh(senseHigh), .dieHot(dieHot), .csShort(csShort), .vccOver(vccOver),
    .diodeShort(diodeShort), .zcdLow(zcdLow), .gateEn(gateEn),
    .startupMode(startupMode), .stateCode(stateCode));

  task automatic check(input string tag, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearFaults();
    brownOut = 0; senseLow = 0; senseRelease = 0; senseHigh = 0; dieHot = 0;
    csShort = 0; vccOver = 0; diodeShort = 0; zcdLow = 0;
  endtask

  task automatic goReset();
    clearFaults();
    vccBelowReset = 1; vccBelowStop = 1; vccAboveStart = 0;
    cyc(2);
  endtask

  task automatic powerUp();
    vccBelowReset = 0; vccBelowStop = 0; vccAboveStart = 1;
  endtask

  // Expected landing state for a single fault injected in run (R4..R7).
  function automatic int expectFault(input int idx, input logic latched);
    if (latched && (idx == 2 || idx == 3 || idx == 5)) return 5;
    if (idx == 7) return 0;
    if (idx == 6) return 3;
    return 4;
  endfunction

  task automatic setFault(input int idx);
    case (idx)
      0: vccOver = 1;
      1: senseHigh = 1;
      2: diodeShort = 1;
      3: zcdLow = 1;
      4: csShort = 1;
      5: senseLow = 1;
      6: dieHot = 1;
      default: brownOut = 1;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cyc(3);
    rstN = 1;
    cyc(1);
    check("R1 reset state", stateCode, 0);
    check("R1 gate off", gateEn, 0);
    check("R1 startup mode", startupMode, 1);

    // R2: exact settle window before run
    powerUp();
    cyc(9);
    check("R2 still stop", stateCode, 1);
    check("R2 gate withheld", gateEn, 0);
    cyc(1);
    check("R2 run entered", stateCode, 2);
    check("R2 gate on", gateEn, 1);

    // R3: supply falls below stop
    vccBelowStop = 1; vccAboveStart = 0;
    cyc(1);
    check("R3 discharge", stateCode, 3);
    check("R3 gate off", gateEn, 0);
    cyc(1);
    check("R3 back to reset", stateCode, 0);

    // R11: no tick, no progress
    goReset();
    tick = 0;
    powerUp();
    cyc(30);
    check("R11 frozen in stop", stateCode, 1);
    tick = 1;
    cyc(10);
    check("R11 run after ticks", stateCode, 2);

    // R10: short over-voltage pulse ignored, long one confirmed
    senseHigh = 1; cyc(2); senseHigh = 0; cyc(3);
    check("R10 glitch ignored", stateCode, 2);
    senseHigh = 1; cyc(6);
    check("R10 confirmed to recover", stateCode, 4);
    senseHigh = 0;

    // R4: timer expiry leads to discharge, fresh climb needed
    cyc(25);
    check("R4 discharge after timer", stateCode, 3);
    vccBelowStop = 1; vccAboveStart = 0; cyc(2);
    check("R4 reset after drop", stateCode, 0);
    powerUp(); cyc(12);
    check("R4 run after climb", stateCode, 2);

    // R8: over-temperature in auto variant needs release
    senseLow = 1; cyc(6);
    check("R8 recover entered", stateCode, 4);
    senseLow = 0; cyc(30);
    check("R8 held without release", stateCode, 4);
    senseRelease = 1; cyc(2);
    check("R8 released", stateCode, 3);
    goReset(); powerUp(); cyc(12);

    // R6: die thermal shutdown
    dieHot = 1; cyc(2);
    check("R6 discharge", stateCode, 3);
    goReset(); powerUp(); cyc(12);

    // R5: brown-out holds reset, then straight to stop
    brownOut = 1; cyc(2);
    check("R5 reset", stateCode, 0);
    cyc(5);
    check("R5 held", stateCode, 0);
    brownOut = 0; cyc(1);
    check("R5 straight to stop", stateCode, 1);
    cyc(12);

    // R9: auxiliary short filter
    zcdLow = 1; cyc(5); zcdLow = 0; cyc(2);
    check("R9 short run ignored", stateCode, 2);
    zcdLow = 1; cyc(8);
    check("R9 aux short auto recover", stateCode, 4);

    // R7: latch and supply hiccup, R12 exit
    goReset(); latchedVariant = 1; powerUp(); cyc(12);
    diodeShort = 1; cyc(2);
    check("R7 latch entered", stateCode, 5);
    diodeShort = 0; cyc(5);
    check("R7 latch held", stateCode, 5);
    check("R7 not charging", startupMode, 0);
    vccBelowStop = 1; vccAboveStart = 0; cyc(2);
    check("R7 latch through stop level", stateCode, 5);
    check("R7 charging", startupMode, 1);
    vccBelowStop = 0; vccAboveStart = 1; cyc(2);
    check("R7 charge ends", startupMode, 0);
    vccBelowReset = 1; cyc(1);
    check("R12 latch cleared", stateCode, 0);

    // Random single faults under both variants (R4 R5 R6 R7)
    for (int i = 0; i < 24; i++) begin
      int idx;
      logic lv;
      idx = int'($urandom_range(0, 7));
      lv  = 1'($urandom_range(0, 1));
      goReset();
      latchedVariant = lv;
      powerUp(); cyc(12);
      check("R2 random run", stateCode, 2);
      setFault(idx);
      cyc(12);
      check("R4 R7 random landing", stateCode, expectFault(idx, lv));
    end
    goReset();

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule